// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache with Victim Buffer

This block is a two-way set-associative data cache. It sits between a processor load/store port and a lower-level memory. The processor hands in one 64-bit word access at a time: a word address, a read/write flag, write data and per-byte enables, with a valid/ready handshake. The cache answers with a one-cycle done pulse that carries the read data. Stores update only the cached copy. Memory sees a modified line only when that line is replaced.

On a miss, the cache picks a way in the addressed set. It takes an empty way if one exists, and otherwise the least recently used way. A modified victim line is handed to a one-entry victim buffer, and the refill of the new line starts straight away. The buffer writes its line to memory on its own, one beat at a time. If a miss asks for the very line that is waiting in the buffer, the line moves back into the cache without a memory read, and the pending write for it is dropped. A refill brings in the whole line as consecutive 64-bit beats, and the access completes only after the line is installed.

With default parameters the cache holds 512 sets of two 64-byte lines (64 KiB) in a 44-bit physical address space.

Top module: `cache_wb2way`

## Requirements
- R1: After reset no line is valid: `req_ready` is 1, `resp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0, and the first access to any address misses and issues a line read.
- R2: A byte address splits into a 6-bit line offset (bits 5:0, with bits 5:3 choosing the word), an index (bits 14:6 by default) and a tag made of all remaining upper bits. A hit needs a valid line whose full tag matches, so addresses differing only in bit 43 are different lines.
- R3: Counting from the clock edge that accepts a request, a load hit raises `resp_valid` after 2 edges and a store hit after 3 edges.
- R4: A store changes cached data only after its tag check has hit. Only the bytes whose `req_be` bit is 1 change (bit k covers data bits 8k+7:8k), and a later load returns the merged word.
- R5: Stores never write memory directly. A modified line reaches memory only after eviction, as eight 64-bit beats whose byte addresses run upward from the line base in steps of 8.
- R6: On a miss, an invalid way is refilled before any valid way. When both ways are valid, the least recently used way of that set is replaced.
- R7: A refill issues exactly one read request at the line-aligned byte address and takes eight data beats in address order. The response comes only after all eight beats, and a load returns the word at its address.
- R8: A modified victim goes to the victim buffer, and the refill request is issued while that buffer is still waiting to write to memory.
- R9: If a miss must evict a modified line while the victim buffer is still full, no refill request is issued and no response is given until the buffer has drained.
- R10: A miss on the line held in the victim buffer installs it from the buffer with no memory read. The buffer entry is cancelled, so none of its beats reach memory, and the line stays modified, so a later eviction writes it back.
- R11: `resp_valid` is a single-cycle pulse, and `req_ready` is 1 only while the cache is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_waddr | input | ADDR_W-3 | Word address (byte address bits 43:3) |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| resp_valid | output | 1 | Access done pulse |
| resp_rdata | output | 64 | Word read, valid with `resp_valid` |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | ADDR_W | Line-aligned byte address of the read |
| mem_rdata_valid | input | 1 | Refill beat present |
| mem_rdata | input | 64 | Refill beat data |
| mem_wr_valid | output | 1 | Victim write beat present |
| mem_wr_ready | input | 1 | Memory accepts the write beat |
| mem_wr_addr | output | ADDR_W | Byte address of the write beat |
| mem_wr_data | output | 64 | Write beat data |

## Verification
The bench builds the cache with 4 sets, keeping the 44-bit address and 64-byte lines. Conflict misses, dirty evictions, a full victim buffer and hits on the buffered line then happen within a handful of accesses to one set. The directed sequence walks one set through invalid-first filling, LRU choice, a stall behind a blocked buffer, and a swap where the buffered line returns while a new dirty victim takes its place. A constrained random phase follows, using six small tags (some with bit 43 set) over all sets, with random memory readiness. Every load in it is compared against a word-level image of all stores.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int WORD_W     = 64;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WOFF_W     = $clog2(WORD_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_STORE,
        ST_RESP,
        ST_FILL_REQ,
        ST_FILL,
        ST_INSTALL
    } ctl_state_e;

    typedef struct packed {
        logic                  write;
        logic [WORD_W-1:0]     wdata;
        logic [WORD_BYTES-1:0] be;
    } req_op_t;

    // Replace the enabled bytes of a word.
    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0]     old_w,
        input logic [WORD_W-1:0]     new_w,
        input logic [WORD_BYTES-1:0] be
    );
        logic [WORD_W-1:0] res;
        for (int b = 0; b < WORD_BYTES; b++) begin
            res[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cache_ways.sv
module cache_ways #(
    parameter int SETS   = 512,
    parameter int TAG_W  = 29,
    parameter int LINE_W = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(SETS)-1:0]   rd_idx,
    output logic [1:0]                rd_valid,
    output logic [1:0]                rd_dirty,
    output logic [1:0][TAG_W-1:0]     rd_tag,
    output logic [1:0][LINE_W-1:0]    rd_line,
    output logic                      rd_lru,
    input  logic                      wr_en,
    input  logic                      wr_way,
    input  logic [$clog2(SETS)-1:0]   wr_idx,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [LINE_W-1:0]         wr_line,
    input  logic                      wr_dirty,
    input  logic                      lru_we,
    input  logic                      lru_val
);
    localparam int WAYS = 2;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   valid_q;
        logic [SETS-1:0]   dirty_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [LINE_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (wr_en && wr_way == 1'(w)) begin
                valid_q[wr_idx] <= 1'b1;
                dirty_q[wr_idx] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                tag_q[wr_idx]  <= wr_tag;
                line_q[wr_idx] <= wr_line;
            end
        end

        assign rd_valid[w] = valid_q[rd_idx];
        assign rd_dirty[w] = dirty_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
        assign rd_line[w]  = line_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)         lru_q <= '0;
        else if (lru_we) lru_q[rd_idx] <= lru_val;
    end

    assign rd_lru = lru_q[rd_idx];

    // Both ways of a set never hold the same line.
    assert_unique_tag_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid == 2'b11) |-> (rd_tag[0] != rd_tag[1]));

endmodule

// File: rtl/cache_victim_buf.sv
module cache_victim_buf
    import cache_pkg::*;
#(
    parameter int LADDR_W    = 38,
    parameter int LINE_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [LADDR_W-1:0]            push_laddr,
    input  logic [LINE_BYTES*8-1:0]       push_line,
    input  logic                          cancel,
    output logic                          valid,
    output logic [LADDR_W-1:0]            laddr,
    output logic [LINE_BYTES*8-1:0]       line,
    output logic                          mem_wr_valid,
    input  logic                          mem_wr_ready,
    output logic [LADDR_W+$clog2(LINE_BYTES)-1:0] mem_wr_addr,
    output logic [WORD_W-1:0]             mem_wr_data
);
    localparam int BEATS  = LINE_BYTES / WORD_BYTES;
    localparam int BEAT_W = $clog2(BEATS);

    logic                     valid_q;
    logic [LADDR_W-1:0]       laddr_q;
    logic [LINE_BYTES*8-1:0]  line_q;
    logic [BEAT_W-1:0]        beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (push) begin
            valid_q <= 1'b1;
            laddr_q <= push_laddr;
            line_q  <= push_line;
            beat_q  <= '0;
        end else if (cancel) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (valid_q && mem_wr_ready) begin
            if (beat_q == BEAT_W'(BEATS - 1)) begin
                valid_q <= 1'b0;
                beat_q  <= '0;
            end else begin
                beat_q  <= beat_q + 1'b1;
            end
        end
    end

    assign valid        = valid_q;
    assign laddr        = laddr_q;
    assign line         = line_q;
    assign mem_wr_valid = valid_q;
    assign mem_wr_addr  = {laddr_q, beat_q, {WOFF_W{1'b0}}};
    assign mem_wr_data  = line_q[int'(beat_q)*WORD_W +: WORD_W];

    // A new victim is accepted only into an empty or just-cancelled entry.
    assert_vb_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> (!valid_q || cancel));

    // A stalled write beat keeps its address.
    assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !mem_wr_ready && !push && !cancel) |=> $stable(mem_wr_addr));

endmodule

// File: rtl/cache_wb2way.sv
module cache_wb2way
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 44,
    parameter int SETS       = 512,
    parameter int LINE_BYTES = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-WOFF_W-1:0] req_waddr,
    input  logic [WORD_W-1:0]        req_wdata,
    input  logic [WORD_BYTES-1:0]    req_be,
    output logic                     resp_valid,
    output logic [WORD_W-1:0]        resp_rdata,
    output logic                     mem_rd_valid,
    input  logic                     mem_rd_ready,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic                     mem_rdata_valid,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     mem_wr_valid,
    input  logic                     mem_wr_ready,
    output logic [ADDR_W-1:0]        mem_wr_addr,
    output logic [WORD_W-1:0]        mem_wr_data
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int WA_W    = ADDR_W - WOFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int BEATS   = LINE_BYTES / WORD_BYTES;
    localparam int BEAT_W  = $clog2(BEATS);

    ctl_state_e state_q, state_d;
    logic [WA_W-1:0]   waddr_q;
    req_op_t           op_q;
    logic              way_q, hway_q, from_vb_q;
    logic [BEAT_W-1:0] beat_q;
    logic [LINE_W-1:0] fill_q;

    // Address fields of the request in flight
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic [LADDR_W-1:0] laddr;
    logic [BEAT_W-1:0]  word;
    assign idx   = waddr_q[BEAT_W +: IDX_W];
    assign tag   = waddr_q[WA_W-1 -: TAG_W];
    assign laddr = waddr_q[WA_W-1:BEAT_W];
    assign word  = waddr_q[BEAT_W-1:0];

    logic [1:0]              rd_valid, rd_dirty;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0][LINE_W-1:0]  rd_line;
    logic                    rd_lru;
    logic                    arr_we, arr_way, arr_dirty, lru_we, lru_val;
    logic [LINE_W-1:0]       arr_line, st_line;
    logic                    vb_valid, vb_push, vb_cancel;
    logic [LADDR_W-1:0]      vb_laddr;
    logic [LINE_W-1:0]       vb_line;
    logic [1:0]              hit_vec;
    logic                    hit, hit_way, vic_way, ev_way, ev_dirty, vb_match;

    cache_ways #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) ways_i (
        .clk, .rst,
        .rd_idx(idx), .rd_valid, .rd_dirty, .rd_tag, .rd_line, .rd_lru,
        .wr_en(arr_we), .wr_way(arr_way), .wr_idx(idx), .wr_tag(tag),
        .wr_line(arr_line), .wr_dirty(arr_dirty),
        .lru_we, .lru_val
    );

    cache_victim_buf #(.LADDR_W(LADDR_W), .LINE_BYTES(LINE_BYTES)) vbuf_i (
        .clk, .rst,
        .push(vb_push), .push_laddr({rd_tag[ev_way], idx}), .push_line(rd_line[ev_way]),
        .cancel(vb_cancel), .valid(vb_valid), .laddr(vb_laddr), .line(vb_line),
        .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
    );

    // Tag compare and victim choice
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == tag);
    end
    assign hit      = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign vic_way  = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : rd_lru);
    assign ev_way   = (state_q == ST_INSTALL) ? way_q : vic_way;
    assign ev_dirty = rd_valid[ev_way] && rd_dirty[ev_way];
    assign vb_match = vb_valid && (vb_laddr == laddr);

    always_comb begin
        st_line = rd_line[hway_q];
        st_line[int'(word)*WORD_W +: WORD_W] =
            merge_bytes(rd_line[hway_q][int'(word)*WORD_W +: WORD_W], op_q.wdata, op_q.be);
    end

    always_comb begin
        state_d   = state_q;
        arr_we    = 1'b0;
        arr_way   = way_q;
        arr_line  = from_vb_q ? vb_line : fill_q;
        arr_dirty = from_vb_q;
        lru_we    = 1'b0;
        lru_val   = ~hit_way;
        vb_push   = 1'b0;
        vb_cancel = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit) begin
                    lru_we  = 1'b1;
                    state_d = op_q.write ? ST_STORE : ST_RESP;
                end else if (vb_match) begin
                    state_d = ST_INSTALL;
                end else if (!(ev_dirty && vb_valid)) begin
                    vb_push = ev_dirty;
                    state_d = ST_FILL_REQ;
                end
            end
            ST_STORE: begin
                arr_we    = 1'b1;
                arr_way   = hway_q;
                arr_line  = st_line;
                arr_dirty = 1'b1;
                state_d   = ST_RESP;
            end
            ST_RESP:     state_d = ST_IDLE;
            ST_FILL_REQ: if (mem_rd_ready) state_d = ST_FILL;
            ST_FILL:     if (mem_rdata_valid && beat_q == BEAT_W'(BEATS - 1)) state_d = ST_INSTALL;
            ST_INSTALL: begin
                arr_we    = 1'b1;
                vb_cancel = from_vb_q;
                vb_push   = from_vb_q && ev_dirty;
                state_d   = ST_LOOKUP;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    waddr_q <= req_waddr;
                    op_q    <= '{write: req_write, wdata: req_wdata, be: req_be};
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        hway_q <= hit_way;
                    end else begin
                        way_q     <= vic_way;
                        from_vb_q <= vb_match;
                    end
                end
                ST_FILL_REQ: beat_q <= '0;
                ST_FILL: if (mem_rdata_valid) begin
                    fill_q[int'(beat_q)*WORD_W +: WORD_W] <= mem_rdata;
                    beat_q <= beat_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign resp_valid   = (state_q == ST_RESP);
    assign resp_rdata   = rd_line[hway_q][int'(word)*WORD_W +: WORD_W];
    assign mem_rd_valid = (state_q == ST_FILL_REQ);
    assign mem_rd_addr  = {laddr, {OFF_W{1'b0}}};

    // A store commits only right after a lookup that hit.
    assert_store_after_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STORE) |-> ($past(state_q) == ST_LOOKUP && $past(hit)));

    // The done pulse lasts one cycle and is followed by readiness.
    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    // After a hit the other way of that set becomes least recently used.
    assert_lru_update_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && hit) |=> (rd_lru == !$past(hit_way)));

    // Memory is never asked for a line sitting in the victim buffer.
    assert_no_read_of_buffered_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !vb_match);

endmodule

// File: tb/cache_wb2way_tb.sv
module cache_wb2way_tb_top;
    import cache_pkg::*;

    localparam int ADDR_W     = 44;
    localparam int SETS       = 4;
    localparam int LINE_BYTES = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              req_valid, req_ready, req_write;
    logic [ADDR_W-4:0] req_waddr;
    logic [63:0]       req_wdata;
    logic [7:0]        req_be;
    logic              resp_valid;
    logic [63:0]       resp_rdata;
    logic              mem_rd_valid, mem_rd_ready;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rdata_valid;
    logic [63:0]       mem_rdata;
    logic              mem_wr_valid, mem_wr_ready;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [63:0]       mem_wr_data;

    cache_wb2way #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) dut_i (
        .clk, .rst, .req_valid, .req_ready, .req_write, .req_waddr, .req_wdata, .req_be,
        .resp_valid, .resp_rdata, .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
        .mem_rdata_valid, .mem_rdata, .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    logic [63:0] mem_img [logic [43:0]];
    logic [63:0] gold    [logic [43:0]];

    function automatic logic [63:0] init_pat(input logic [43:0] a);
        return {a[31:0] ^ 32'h5A3C_96E1, a[43:12]};
    endfunction

    function automatic logic [63:0] mem_word(input logic [43:0] a);
        logic [43:0] k = {a[43:3], 3'b000};
        return mem_img.exists(k) ? mem_img[k] : init_pat(k);
    endfunction

    function automatic logic [63:0] gold_word(input logic [43:0] a);
        logic [43:0] k = {a[43:3], 3'b000};
        return gold.exists(k) ? gold[k] : init_pat(k);
    endfunction

    function automatic logic [63:0] with_bytes(input logic [63:0] o, input logic [63:0] n,
                                               input logic [7:0] be);
        logic [63:0] r = o;
        for (int i = 0; i < 8; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    // Byte address for the 4-set build: tag above bit 8, index bits 7:6, word bits 5:3.
    function automatic logic [43:0] mk(input logic [35:0] t, input int idx, input int w);
        return {t, 2'(idx), 3'(w), 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model, acting between clock edges
    int          fill_reqs = 0;
    int          wr_beats  = 0;
    int          wr_budget = 0;
    bit          fill_busy = 1'b0;
    logic [43:0] fill_base;
    int          fill_idx;
    logic [43:0] last_wr;

    always @(negedge clk) begin
        if (rst) begin
            mem_rd_ready    = 1'b0;
            mem_rdata_valid = 1'b0;
            mem_rdata       = '0;
            mem_wr_ready    = 1'b0;
        end else begin
            if (resp_valid && fill_busy)
                check(1'b0, "R7 response before full line", 64'(fill_idx), 64'd8);
            mem_rd_ready    = ($urandom % 3) != 0;
            mem_rdata_valid = 1'b0;
            if (fill_busy) begin
                if (($urandom % 4) != 0) begin
                    mem_rdata_valid = 1'b1;
                    mem_rdata = mem_word(fill_base + 44'(fill_idx * 8));
                    fill_idx++;
                    if (fill_idx == 8) fill_busy = 1'b0;
                end
            end else if (mem_rd_valid && mem_rd_ready) begin
                fill_reqs++;
                check(mem_rd_addr[5:0] == 6'd0, "R7 line-aligned read address",
                      64'(mem_rd_addr), 64'(mem_rd_addr & ~44'h3F));
                fill_base = mem_rd_addr;
                fill_idx  = 0;
                fill_busy = 1'b1;
            end
            mem_wr_ready = (wr_budget > 0) && (($urandom % 4) != 0);
            if (mem_wr_valid && mem_wr_ready) begin
                wr_budget--;
                wr_beats++;
                if (mem_wr_addr[5:3] != 3'd0)
                    check(mem_wr_addr == last_wr + 44'd8, "R5 write beat order",
                          64'(mem_wr_addr), 64'(last_wr + 44'd8));
                last_wr = mem_wr_addr;
                mem_img[mem_wr_addr] = mem_wr_data;
            end
        end
    end

    task automatic access(input bit wr, input logic [43:0] a, input logic [63:0] d,
                          input logic [7:0] be, output logic [63:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_waddr = a[43:3]; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
        if (wr) gold[{a[43:3], 3'b000}] = with_bytes(gold_word(a), d, be);
    endtask

    task automatic load_chk(input logic [43:0] a, input string req, output int lat);
        logic [63:0] rd;
        access(1'b0, a, 64'd0, 8'h00, rd, lat);
        check(rd == gold_word(a), req, rd, gold_word(a));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    logic [43:0] A, B, C, D, E, F, G, H;
    logic [63:0] rdv;
    int          lat, f0, w0;
    bit          e_done;

    initial begin
        void'($urandom(32'd20240401));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_waddr = '0;
        req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_rd_valid && !mem_wr_valid, "R1 reset outputs",
              {60'd0, req_ready, resp_valid, mem_rd_valid, mem_wr_valid}, 64'h8);

        A = mk(36'd1, 0, 3); B = mk(36'd2, 0, 0); C = mk(36'd3, 0, 6);
        D = mk(36'd4, 0, 5); E = mk(36'd5, 0, 1); F = mk(36'd6, 0, 2);
        G = mk(36'd7, 0, 4); H = G | (44'h1 << 43);

        // Cold miss, then hits
        f0 = fill_reqs;
        load_chk(A, "R7 miss load data", lat);
        check(fill_reqs == f0 + 1, "R1 first access misses", 64'(fill_reqs - f0), 64'd1);
        f0 = fill_reqs;
        load_chk(A, "R3 hit load data", lat);
        check(lat == 2, "R3 load hit latency", 64'(lat), 64'd2);
        check(fill_reqs == f0, "R2 hit issues no read", 64'(fill_reqs - f0), 64'd0);

        // Partial store
        access(1'b1, A, 64'hDEAD_BEEF_0BAD_F00D, 8'h0F, rdv, lat);
        check(lat == 3, "R3 store hit latency", 64'(lat), 64'd3);
        load_chk(A, "R4 merged bytes", lat);
        check(mem_word(A) == init_pat(A), "R5 no write-through", mem_word(A), init_pat(A));
        check(wr_beats == 0, "R5 no write beats on store", 64'(wr_beats), 64'd0);

        // Invalid way first, then LRU
        load_chk(B, "R6 second line data", lat);
        load_chk(A, "R6 A still present", lat);
        check(lat == 2, "R6 A kept after fill into empty way", 64'(lat), 64'd2);
        load_chk(C, "R6 C data", lat);
        check(wr_beats == 0, "R5 clean victim not written", 64'(wr_beats), 64'd0);
        load_chk(A, "R6 LRU kept A", lat);
        check(lat == 2, "R6 LRU victim was B", 64'(lat), 64'd2);
        load_chk(C, "R6 C hit", lat);
        check(lat == 2, "R6 C hit latency", 64'(lat), 64'd2);

        // Dirty A evicted into the blocked victim buffer
        wr_budget = 0;
        f0 = fill_reqs;
        load_chk(D, "R8 refill completes with writes blocked", lat);
        check(fill_reqs == f0 + 1 && wr_beats == 0 && mem_wr_valid, "R8 refill ahead of writeback",
              {62'd0, mem_wr_valid, 1'b0} | 64'(wr_beats), 64'h2);

        access(1'b1, D, 64'h1111_2222_3333_4444, 8'hFF, rdv, lat);
        access(1'b1, C, 64'h5555_6666_7777_8888, 8'hF0, rdv, lat);

        // Dirty D must be evicted while the buffer still holds A
        f0 = fill_reqs; w0 = wr_beats; e_done = 1'b0;
        fork
            begin
                load_chk(E, "R9 data after stall", lat);
                e_done = 1'b1;
            end
            begin
                repeat (30) @(negedge clk);
                check(fill_reqs == f0, "R9 no refill while buffer full", 64'(fill_reqs - f0), 64'd0);
                check(!e_done, "R9 no response while buffer full", 64'(e_done), 64'd0);
                wr_budget = 8;
            end
        join
        check(wr_beats == w0 + 8, "R5 eight beats for A", 64'(wr_beats - w0), 64'd8);
        check(mem_word(A) == gold_word(A), "R5 A written back", mem_word(A), gold_word(A));

        // D comes back from the buffer, dirty C is swapped in
        f0 = fill_reqs;
        load_chk(D, "R10 data from buffer", lat);
        check(fill_reqs == f0, "R10 no memory read", 64'(fill_reqs - f0), 64'd0);
        w0 = wr_beats;
        wr_budget = 8;
        for (int i = 0; i < 200 && wr_beats < w0 + 8; i++) @(negedge clk);
        check(mem_word(C) == gold_word(C), "R10 swapped victim written", mem_word(C), gold_word(C));
        check(mem_word(D) == init_pat(D), "R10 cancelled entry not written", mem_word(D), init_pat(D));

        // D is still dirty: evict it
        wr_budget = 1000000;
        load_chk(F, "R6 F data", lat);
        load_chk(G, "R10 G data", lat);
        for (int i = 0; i < 200 && mem_wr_valid; i++) @(negedge clk);
        check(mem_word(D) == gold_word(D), "R10 line stayed dirty", mem_word(D), gold_word(D));

        // Tag covers the top address bit
        f0 = fill_reqs;
        load_chk(H, "R2 top-bit alias data", lat);
        check(fill_reqs == f0 + 1, "R2 top-bit alias misses", 64'(fill_reqs - f0), 64'd1);
        load_chk(G, "R2 original line data", lat);

        // Constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [35:0] t;
            logic [43:0] a;
            t = 36'($urandom % 6);
            if (($urandom % 5) == 0) t[35] = 1'b1;
            a = mk(t, int'($urandom % SETS), int'($urandom % 8));
            if (($urandom % 10) < 4)
                access(1'b1, a, {$urandom, $urandom}, 8'($urandom), rdv, lat);
            else
                load_chk(a, "R4 random load matches stores", lat);
        end

        finish_run();
    end

endmodule